// File: doc/BRIEF.md
# SMRAM access control unit

This block holds the control byte that governs the system-management memory window and decides, for every access into that window, where the access is sent. Software updates the byte through a one-cycle write strobe. The block then sanitises the written value: the reserved top bit is dropped and the three low bits are forced to a fixed segment code. A sticky lock bit, once set, survives every later write until a power-on reset. While it is set, the open bit cannot be turned back on.

The routing side has no clock. It combines the current control byte with the processor's system-management indication and a code/data qualifier, and names the target: DRAM, the PCI bus, or an illegal setup. The illegal case also raises an error flag. When the window is closed, instruction fetches and data accesses are routed separately, which lets handler code run from the hidden memory while its data references fall through to the bus.

Top module: `smram_ctrl_unit`

## Requirements
- R1: A write while unlocked stores `{1'b0, wr_data[6:3], 3'b010}`. Bit 7 of the register always reads 0 and bits 2:0 always read 3'b010.
- R2: The register bits are open = bit 6, closed = bit 5, lock = bit 4 and enable = bit 3. Once lock reads 1, it stays 1 across all writes until `rst` is asserted.
- R3: A write that arrives while lock is already 1 stores open = 0 and lock = 1. Closed and enable still take `wr_data[5]` and `wr_data[3]`.
- R4: With enable = 0, `route_o` is PCI (2'b00) for every access and `cfg_err_o` is 0.
- R5: With enable = 1, lock = 0, open = 1 and closed = 0, `route_o` is DRAM (2'b01) for code and data, both inside and outside SMM.
- R6: With enable = 1 and `in_smm` = 0, the route is PCI whenever open = 0 or lock = 1.
- R7: With enable = 1, `in_smm` = 1 and closed = 0, the route is DRAM for code and data.
- R8: With enable = 1, `in_smm` = 1, closed = 1, and either open = 0 or lock = 1, code fetches (`is_code` = 1) go to DRAM and data accesses go to PCI.
- R9: With enable = 1, lock = 0, open = 1 and closed = 1, `route_o` is ILLEGAL (2'b10) and `cfg_err_o` is 1. In every other state `cfg_err_o` is 0.
- R10: After `rst` the register reads 8'h02. It changes only on a rising clock edge with `wr_en` = 1; `wr_data` has no effect while `wr_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset; also clears the lock |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value offered to the control byte |
| in_smm | input | 1 | Processor is in system-management mode |
| is_code | input | 1 | 1 = instruction fetch, 0 = data access |
| ctl_q | output | 8 | Current control byte |
| route_o | output | 2 | Access target: 00 PCI, 01 DRAM, 10 ILLEGAL |
| cfg_err_o | output | 1 | Illegal open-and-closed setup while unlocked |

## Verification
A register write and an access decode can fall in the same cycle. In that cycle the route must still follow the old control byte, and the new byte must take over only after the clock edge. The bench provokes this by holding a write strobe and an access together. It queues one expectation computed from the pre-edge model and a second from the post-edge model, and compares both. It also writes the open bit while the lock is already set, in the same cycle as an SMM data access. This checks that the lock is honoured both by the write and by the decode that follows.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int CTL_W      = 8;
    localparam int SEG_W      = 3;
    localparam logic [SEG_W-1:0] SEG_FIXED = 3'b010;
    localparam logic [CTL_W-1:0] CTL_RESET = {1'b0, 4'b0000, SEG_FIXED};

    typedef struct packed {
        logic             rsvd;
        logic             open;
        logic             closed;
        logic             lock;
        logic             enable;
        logic [SEG_W-1:0] seg;
    } smram_ctl_t;

    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
        logic enable;
    } smram_mode_t;

    typedef enum logic [1:0] {
        ROUTE_PCI  = 2'b00,
        ROUTE_DRAM = 2'b01,
        ROUTE_BAD  = 2'b10
    } route_e;

    // Sanitise a written byte against the currently held control state.
    function automatic smram_ctl_t smram_merge(input smram_ctl_t cur,
                                               input logic [CTL_W-1:0] data);
        smram_ctl_t m;
        m      = smram_ctl_t'(data);
        m.rsvd = 1'b0;
        m.seg  = SEG_FIXED;
        if (cur.lock) begin
            m.open = 1'b0;
            m.lock = 1'b1;
        end
        return m;
    endfunction

    function automatic smram_mode_t smram_mode(input smram_ctl_t c);
        smram_mode_t r;
        r.open   = c.open;
        r.closed = c.closed;
        r.lock   = c.lock;
        r.enable = c.enable;
        return r;
    endfunction

endpackage

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output smram_ctl_t       ctl_q
);

    smram_ctl_t ctl_r;
    smram_ctl_t ctl_nxt;

    always_comb begin
        ctl_nxt = ctl_r;
        if (wr_en) ctl_nxt = smram_merge(ctl_r, wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_r <= smram_ctl_t'(CTL_RESET);
        else     ctl_r <= ctl_nxt;
    end

    assign ctl_q = ctl_r;

    // R1: reserved and segment fields never deviate
    p_fixed_fields_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_r.rsvd == 1'b0) && (ctl_r.seg == SEG_FIXED));

    // R2: lock is sticky until power-on reset
    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_r.lock) |-> ctl_r.lock);

    // R3: a write under lock leaves open cleared
    p_lock_closes_open_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctl_r.lock) |=> !ctl_r.open);

    // R10: reset value and no change without strobe
    p_reset_value_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_r == smram_ctl_t'(CTL_RESET)));

    p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_r));

endmodule

// File: rtl/smram_route.sv
module smram_route
    import smram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  smram_mode_t mode,
    input  logic        in_smm,
    input  logic        is_code,
    output route_e      route,
    output logic        cfg_err
);

    logic open_eff;   // open counts only while unlocked
    logic clash;

    always_comb begin
        open_eff = mode.open && !mode.lock;
        clash    = mode.enable && open_eff && mode.closed;
    end

    always_comb begin
        route = ROUTE_PCI;
        if (!mode.enable) begin
            route = ROUTE_PCI;
        end else if (clash) begin
            route = ROUTE_BAD;
        end else if (open_eff) begin
            route = ROUTE_DRAM;
        end else if (!in_smm) begin
            route = ROUTE_PCI;
        end else if (mode.closed && !is_code) begin
            route = ROUTE_PCI;
        end else begin
            route = ROUTE_DRAM;
        end
    end

    assign cfg_err = clash;

    // R4: disabled window always goes to the bus
    p_disabled_pci_r4: assert property (@(posedge clk) disable iff (rst)
        !mode.enable |-> (route == ROUTE_PCI) && !cfg_err);

    // R6: outside SMM without an effective open bit, bus only
    p_outside_smm_r6: assert property (@(posedge clk) disable iff (rst)
        (!in_smm && (!mode.open || mode.lock)) |-> (route != ROUTE_DRAM));

    // R8: closed window never serves data from DRAM
    p_closed_data_r8: assert property (@(posedge clk) disable iff (rst)
        (mode.closed && !is_code && (!mode.open || mode.lock)) |-> (route == ROUTE_PCI));

    // R9: the error flag and the illegal route agree
    p_err_match_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err == (route == ROUTE_BAD));

    p_err_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !mode.lock);

endmodule

// File: rtl/smram_ctrl_unit.sv
module smram_ctrl_unit
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             in_smm,
    input  logic             is_code,
    output logic [CTL_W-1:0] ctl_q,
    output logic [1:0]       route_o,
    output logic             cfg_err_o
);

    smram_ctl_t  ctl;
    smram_mode_t mode;
    route_e      route;

    smram_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl_q   (ctl)
    );

    assign mode = smram_mode(ctl);

    smram_route u_route (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .in_smm  (in_smm),
        .is_code (is_code),
        .route   (route),
        .cfg_err (cfg_err_o)
    );

    assign ctl_q   = ctl;
    assign route_o = route;

endmodule

// File: tb/smram_ctrl_unit_tb.sv
module smram_ctrl_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       in_smm = 1'b0;
    logic       is_code = 1'b0;
    logic [7:0] ctl_q;
    logic [1:0] route_o;
    logic       cfg_err_o;

    localparam logic [1:0] E_PCI  = 2'b00;
    localparam logic [1:0] E_DRAM = 2'b01;
    localparam logic [1:0] E_BAD  = 2'b10;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] model_ctl;
    logic [10:0] q_exp[$];   // {ctl, route, err}
    string       q_tag[$];

    always #4 clk = ~clk;

    smram_ctrl_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .in_smm(in_smm), .is_code(is_code),
        .ctl_q(ctl_q), .route_o(route_o), .cfg_err_o(cfg_err_o)
    );

    function automatic logic [7:0] model_write(input logic [7:0] cur, input logic [7:0] d);
        logic [7:0] m;
        m = {1'b0, d[6:3], 3'b010};
        if (cur[4]) begin
            m[6] = 1'b0;
            m[4] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [1:0] model_route(input logic [7:0] c, input logic smm, input logic code);
        logic en, op, cl, lk;
        en = c[3]; op = c[6]; cl = c[5]; lk = c[4];
        if (!en)                return E_PCI;
        if (!lk && op && cl)    return E_BAD;
        if (!lk && op)          return E_DRAM;
        if (!smm)               return E_PCI;
        if (cl && !code)        return E_PCI;
        return E_DRAM;
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input string tag);
        logic [1:0] r;
        r = model_route(model_ctl, in_smm, is_code);
        q_exp.push_back({model_ctl, r, (r == E_BAD)});
        q_tag.push_back(tag);
    endtask

    task automatic access(input logic smm, input logic code, input string tag);
        in_smm  = smm;
        is_code = code;
        push(tag);
        cyc();
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        cyc();
        model_ctl = model_write(model_ctl, d);
        wr_en   = 1'b0;
        wr_data = 8'hA5;
    endtask

    // monitor: compare every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0) begin
                logic [10:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if ({ctl_q, route_o, cfg_err_o} !== e) begin
                    errors++;
                    $display("FAIL %s: ctl=%02h route=%b err=%b expected ctl=%02h route=%b err=%b",
                             t, ctl_q, route_o, cfg_err_o, e[10:3], e[2:1], e[0]);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_ctl = 8'h02;
        cyc(); cyc(); cyc();
        rst = 1'b0;
        access(1'b1, 1'b1, "R10 reset value");

        // no strobe: data ignored
        wr_data = 8'hFF;
        cyc();
        access(1'b1, 1'b0, "R10 no write without strobe");

        do_write(8'h87);
        access(1'b1, 1'b1, "R1 masking / R4 disabled");

        do_write(8'h48);
        access(1'b0, 1'b0, "R5 open outside SMM data");
        access(1'b1, 1'b1, "R5 open in SMM code");

        do_write(8'h08);
        access(1'b0, 1'b1, "R6 outside SMM closed window");
        access(1'b1, 1'b0, "R7 SMM data");
        access(1'b1, 1'b1, "R7 SMM code");

        do_write(8'h28);
        access(1'b1, 1'b1, "R8 closed code");
        access(1'b1, 1'b0, "R8 closed data");
        access(1'b0, 1'b1, "R6 closed outside SMM");

        do_write(8'h68);
        access(1'b0, 1'b0, "R9 illegal outside SMM");
        access(1'b1, 1'b1, "R9 illegal in SMM");

        do_write(8'h60);
        access(1'b1, 1'b0, "R4 R9 disabled no error");

        // same-cycle write and decode
        in_smm = 1'b1; is_code = 1'b0;
        wr_en = 1'b1; wr_data = 8'h08;
        push("R10 decode uses old byte during write");
        cyc();
        model_ctl = model_write(model_ctl, 8'h08);
        wr_en = 1'b0;
        access(1'b1, 1'b0, "R7 decode after write edge");

        do_write(8'h58);
        access(1'b0, 1'b0, "R6 locked outside SMM");
        access(1'b1, 1'b0, "R7 locked SMM data");

        // open attempt under lock, same cycle as SMM data access
        in_smm = 1'b1; is_code = 1'b0;
        wr_en = 1'b1; wr_data = 8'h48;
        push("R2 pre-edge locked state");
        cyc();
        model_ctl = model_write(model_ctl, 8'h48);
        wr_en = 1'b0;
        access(1'b0, 1'b0, "R3 open cleared under lock");

        do_write(8'h68);
        access(1'b1, 1'b1, "R8 locked closed code");
        access(1'b1, 1'b0, "R8 R9 locked closed data no error");
        access(1'b0, 1'b1, "R6 locked closed outside SMM");

        do_write(8'h00);
        access(1'b1, 1'b1, "R2 lock survives clearing write");

        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        model_ctl = 8'h02;
        access(1'b1, 1'b0, "R2 R10 power-on reset clears lock");

        cyc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule